// File: doc/BRIEF.md
# Byte-Reorder and Sign-Extend Execution Unit

This unit sits in the execute stage of a 64-bit integer pipeline. It decodes its own 32-bit instruction word, performs one of five small rearrangements on a 64-bit source operand, and returns a registered result one clock later. Three of the operations treat the operand as a 32-bit word or narrower and sign-extend to 64 bits. The other two act on the full doubleword and are allowed only while 64-bit operations are enabled.

The instruction word is split into these fields:

| Bits | Field |
|---|---|
| 31..26 | opcode |
| 25..21 | must-be-zero field |
| 20..16 | source register |
| 15..11 | destination register |
| 10..6 | selector |
| 5..0 | function |

The unit claims only opcode 011111 with function 100000 or 100100. Within that space it reports any encoding it cannot execute as illegal and suppresses the write. It ignores everything else: it produces no result and no illegal report. Register reads, hazards and trap delivery belong to the surrounding pipeline.

Top module: `reorder_unit`

## Requirements
- R1: While `rst` is high at a clock edge, the next outputs are all zero: `res_o`, `dst_o`, `res_valid_o` and `illegal_o`.
- R2: Function 100000 with selector 00010 swaps the two bytes inside each of the two low halfwords of the operand. It then sign-extends the 32-bit value from its bit 31 to 64 bits.
- R3: Function 100000 with selector 10000 copies operand bit 7 into result bits 63..8 and keeps bits 7..0.
- R4: Function 100000 with selector 11000 copies operand bit 15 into result bits 63..16 and keeps bits 15..0.
- R5: Function 100100 with selector 00010 swaps the two bytes inside each of the four halfwords of the operand, while `wide_en_i` is 1.
- R6: Function 100100 with selector 00101 reverses the halfword order: halfword 3 and halfword 0 trade places, and halfword 2 and halfword 1 trade places. This requires `wide_en_i` to be 1.
- R7: The operations of R5 and R6 issued with `wide_en_i` = 0 give `illegal_o` = 1, `res_valid_o` = 0 and `res_o` = 0.
- R8: In the claimed space, certain encodings give `illegal_o` = 1, `res_valid_o` = 0 and `res_o` = 0. These are a selector not listed in R2..R6 for that function, or a nonzero value in bits 25..21.
- R9: An instruction outside the claimed space gives `res_valid_o` = 0, `illegal_o` = 0 and `res_o` = 0. Outside the claimed space means opcode not 011111, or function neither 100000 nor 100100.
- R10: Outputs reflect the instruction presented with `valid_i` = 1 exactly one clock earlier. `dst_o` carries instruction bits 15..11 when `res_valid_o` is 1. A cycle without `valid_i` gives all-zero outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| valid_i | input | 1 | Instruction and operand are present |
| instr_i | input | 32 | Instruction word |
| operand_i | input | 64 | Source operand |
| wide_en_i | input | 1 | 64-bit operations enabled |
| res_o | output | 64 | Registered result |
| dst_o | output | 5 | Destination register index |
| res_valid_o | output | 1 | Result is to be written |
| illegal_o | output | 1 | Claimed encoding could not be executed |

## Verification
Some properties are checked on every cycle. Result-valid and illegal are never high together, and a quiet or illegal cycle always carries a zero result. No output appears without a valid input one cycle earlier. Doubleword operations with 64-bit mode off are always rejected, and the sign-extending operations always give a result whose upper bits all match the source sign bit. The exact byte and halfword placement for each operation is shown only by the bench's vectors. The same holds for the positive and negative sign cases, destination routing, the ignored foreign opcodes and the mid-stream reset.

// File: rtl/reorder_pkg.sv
package reorder_pkg;

    localparam int OPC_W = 6;
    localparam int FLD_W = 5;
    localparam int FN_W  = 6;

    localparam logic [OPC_W-1:0] OPC_SPECIAL3 = 6'b011111;
    localparam logic [FN_W-1:0]  FN_WORD      = 6'b100000;
    localparam logic [FN_W-1:0]  FN_DWORD     = 6'b100100;

    localparam logic [FLD_W-1:0] SEL_BSWAP    = 5'b00010;
    localparam logic [FLD_W-1:0] SEL_SEXT8    = 5'b10000;
    localparam logic [FLD_W-1:0] SEL_SEXT16   = 5'b11000;
    localparam logic [FLD_W-1:0] SEL_HREV     = 5'b00101;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_WSWAP,
        OP_SEXT8,
        OP_SEXT16,
        OP_DSWAP,
        OP_HREV
    } reorder_op_e;

    typedef struct packed {
        logic [OPC_W-1:0] opc;
        logic [FLD_W-1:0] zf;
        logic [FLD_W-1:0] src;
        logic [FLD_W-1:0] dst;
        logic [FLD_W-1:0] sel;
        logic [FN_W-1:0]  fn;
    } instr_t;

    typedef struct packed {
        reorder_op_e      op;
        logic             claim;
        logic             bad;
        logic [FLD_W-1:0] dst;
    } decode_t;

    function automatic logic is_wide(input reorder_op_e op);
        return (op == OP_DSWAP) || (op == OP_HREV);
    endfunction

endpackage

// File: rtl/reorder_decode.sv
module reorder_decode
    import reorder_pkg::*;
(
    input  logic [31:0] instr_i,
    input  logic        wide_en_i,
    output decode_t     dec_o
);
    instr_t      ins;
    reorder_op_e op;

    assign ins = instr_t'(instr_i);

    always_comb begin
        op = OP_NONE;
        if (ins.zf == '0) begin
            if (ins.fn == FN_WORD) begin
                case (ins.sel)
                    SEL_BSWAP:  op = OP_WSWAP;
                    SEL_SEXT8:  op = OP_SEXT8;
                    SEL_SEXT16: op = OP_SEXT16;
                    default:    op = OP_NONE;
                endcase
            end else if (ins.fn == FN_DWORD) begin
                case (ins.sel)
                    SEL_BSWAP: op = OP_DSWAP;
                    SEL_HREV:  op = OP_HREV;
                    default:   op = OP_NONE;
                endcase
            end
        end
    end

    always_comb begin
        dec_o.claim = (ins.opc == OPC_SPECIAL3) &&
                      ((ins.fn == FN_WORD) || (ins.fn == FN_DWORD));
        dec_o.bad   = (op == OP_NONE) || (is_wide(op) && !wide_en_i);
        dec_o.op    = op;
        dec_o.dst   = ins.dst;
    end
endmodule

// File: rtl/reorder_datapath.sv
module reorder_datapath
    import reorder_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  reorder_op_e       op_i,
    input  logic [DATA_W-1:0] a_i,
    output logic [DATA_W-1:0] y_o
);
    localparam int HALF_W  = 16;
    localparam int NHALF   = DATA_W / HALF_W;
    localparam int WORD_W  = 32;

    logic [DATA_W-1:0] bswap;
    logic [DATA_W-1:0] hrev;

    for (genvar h = 0; h < NHALF; h++) begin : g_half
        assign bswap[h*HALF_W +: 8]     = a_i[h*HALF_W + 8 +: 8];
        assign bswap[h*HALF_W + 8 +: 8] = a_i[h*HALF_W +: 8];
        assign hrev[h*HALF_W +: HALF_W] = a_i[(NHALF-1-h)*HALF_W +: HALF_W];
    end

    always_comb begin
        case (op_i)
            OP_WSWAP:  y_o = {{(DATA_W-WORD_W){bswap[WORD_W-1]}}, bswap[WORD_W-1:0]};
            OP_SEXT8:  y_o = {{(DATA_W-8){a_i[7]}}, a_i[7:0]};
            OP_SEXT16: y_o = {{(DATA_W-HALF_W){a_i[HALF_W-1]}}, a_i[HALF_W-1:0]};
            OP_DSWAP:  y_o = bswap;
            OP_HREV:   y_o = hrev;
            default:   y_o = '0;
        endcase
    end
endmodule

// File: rtl/reorder_unit.sv
module reorder_unit
    import reorder_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int IDX_W  = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              valid_i,
    input  logic [31:0]       instr_i,
    input  logic [DATA_W-1:0] operand_i,
    input  logic              wide_en_i,
    output logic [DATA_W-1:0] res_o,
    output logic [IDX_W-1:0]  dst_o,
    output logic              res_valid_o,
    output logic              illegal_o
);
    decode_t           dec;
    logic [DATA_W-1:0] y;
    logic              take;
    logic              reject;

    reorder_decode u_dec (
        .instr_i   (instr_i),
        .wide_en_i (wide_en_i),
        .dec_o     (dec)
    );

    reorder_datapath #(.DATA_W(DATA_W)) u_dp (
        .op_i (dec.op),
        .a_i  (operand_i),
        .y_o  (y)
    );

    assign take   = valid_i && dec.claim && !dec.bad;
    assign reject = valid_i && dec.claim && dec.bad;

    always_ff @(posedge clk) begin
        if (rst) begin
            res_o       <= '0;
            dst_o       <= '0;
            res_valid_o <= 1'b0;
            illegal_o   <= 1'b0;
        end else begin
            res_o       <= take ? y : '0;
            dst_o       <= take ? dec.dst : '0;
            res_valid_o <= take;
            illegal_o   <= reject;
        end
    end
endmodule

// File: rtl/reorder_unit_chk.sv
module reorder_unit_chk #(
    parameter int DATA_W = 64,
    parameter int IDX_W  = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              valid_i,
    input logic [31:0]       instr_i,
    input logic [DATA_W-1:0] operand_i,
    input logic              wide_en_i,
    input logic [DATA_W-1:0] res_o,
    input logic [IDX_W-1:0]  dst_o,
    input logic              res_valid_o,
    input logic              illegal_o
);
    // R10
    out_needs_input_chk: assert property (@(posedge clk) disable iff (rst)
        (res_valid_o || illegal_o) |-> $past(valid_i));

    // R8
    valid_illegal_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(res_valid_o && illegal_o));

    // R7
    illegal_zero_res_chk: assert property (@(posedge clk) disable iff (rst)
        illegal_o |-> (res_o == '0 && dst_o == '0));

    // R9
    quiet_zero_res_chk: assert property (@(posedge clk) disable iff (rst)
        (!res_valid_o && !illegal_o) |-> (res_o == '0));

    // R7
    wide_off_reject_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(valid_i) && $past(instr_i[31:26]) == 6'b011111 &&
         $past(instr_i[5:0]) == 6'b100100 && !$past(wide_en_i)) |-> !res_valid_o);

    // R3
    sext8_sign_chk: assert property (@(posedge clk) disable iff (rst)
        (res_valid_o && $past(instr_i[5:0]) == 6'b100000 &&
         $past(instr_i[10:6]) == 5'b10000)
        |-> (res_o[DATA_W-1:8] == {(DATA_W-8){$past(operand_i[7])}}));

    // R4
    sext16_sign_chk: assert property (@(posedge clk) disable iff (rst)
        (res_valid_o && $past(instr_i[5:0]) == 6'b100000 &&
         $past(instr_i[10:6]) == 5'b11000)
        |-> (res_o[DATA_W-1:16] == {(DATA_W-16){$past(operand_i[15])}}));

    // R2
    wswap_sign_chk: assert property (@(posedge clk) disable iff (rst)
        (res_valid_o && $past(instr_i[5:0]) == 6'b100000 &&
         $past(instr_i[10:6]) == 5'b00010)
        |-> (res_o[DATA_W-1:32] == {(DATA_W-32){$past(operand_i[23])}}));
endmodule

bind reorder_unit reorder_unit_chk #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/reorder_unit_test.sv
`timescale 1ns/1ps
module reorder_unit_test;

    typedef struct packed {
        logic [31:0] ins;
        logic [63:0] opnd;
        logic        wen;
        logic [63:0] exp;
        logic        ev;
        logic        ei;
        logic [7:0]  req;
    } vec_t;

    localparam logic [63:0] A = 64'h0123_4567_89AB_CDEF;
    localparam int NV = 15;

    localparam vec_t VECS [NV] = '{
        // R2 negative word
        '{{6'b011111,5'd0,5'd4,5'd9,5'b00010,6'b100000}, A, 1'b1, 64'hFFFF_FFFF_AB89_EFCD, 1'b1, 1'b0, 8'd2},
        // R2 positive word, upper operand ignored
        '{{6'b011111,5'd0,5'd4,5'd10,5'b00010,6'b100000}, 64'hFFFF_FFFF_1234_5678, 1'b0, 64'h0000_0000_3412_7856, 1'b1, 1'b0, 8'd2},
        // R3 negative byte
        '{{6'b011111,5'd0,5'd1,5'd3,5'b10000,6'b100000}, A, 1'b1, 64'hFFFF_FFFF_FFFF_FFEF, 1'b1, 1'b0, 8'd3},
        // R3 positive byte
        '{{6'b011111,5'd0,5'd1,5'd31,5'b10000,6'b100000}, 64'h8000_0000_0000_807F, 1'b0, 64'h0000_0000_0000_007F, 1'b1, 1'b0, 8'd3},
        // R4 negative halfword
        '{{6'b011111,5'd0,5'd2,5'd5,5'b11000,6'b100000}, A, 1'b1, 64'hFFFF_FFFF_FFFF_CDEF, 1'b1, 1'b0, 8'd4},
        // R4 positive halfword
        '{{6'b011111,5'd0,5'd2,5'd1,5'b11000,6'b100000}, 64'hFFFF_0000_8000_7FFF, 1'b1, 64'h0000_0000_0000_7FFF, 1'b1, 1'b0, 8'd4},
        // R5 doubleword byte swap
        '{{6'b011111,5'd0,5'd7,5'd12,5'b00010,6'b100100}, A, 1'b1, 64'h2301_6745_AB89_EFCD, 1'b1, 1'b0, 8'd5},
        // R6 halfword reversal
        '{{6'b011111,5'd0,5'd7,5'd13,5'b00101,6'b100100}, A, 1'b1, 64'hCDEF_89AB_4567_0123, 1'b1, 1'b0, 8'd6},
        // R7 doubleword swap with 64-bit mode off
        '{{6'b011111,5'd0,5'd7,5'd12,5'b00010,6'b100100}, A, 1'b0, 64'h0, 1'b0, 1'b1, 8'd7},
        // R7 halfword reversal with 64-bit mode off
        '{{6'b011111,5'd0,5'd7,5'd13,5'b00101,6'b100100}, A, 1'b0, 64'h0, 1'b0, 1'b1, 8'd7},
        // R8 unknown selector, word function
        '{{6'b011111,5'd0,5'd7,5'd13,5'b00011,6'b100000}, A, 1'b1, 64'h0, 1'b0, 1'b1, 8'd8},
        // R8 word-only selector under doubleword function
        '{{6'b011111,5'd0,5'd7,5'd13,5'b10000,6'b100100}, A, 1'b1, 64'h0, 1'b0, 1'b1, 8'd8},
        // R8 nonzero bits 25..21
        '{{6'b011111,5'd3,5'd7,5'd13,5'b00010,6'b100000}, A, 1'b1, 64'h0, 1'b0, 1'b1, 8'd8},
        // R9 foreign opcode
        '{{6'b000000,5'd0,5'd7,5'd13,5'b00010,6'b100000}, A, 1'b1, 64'h0, 1'b0, 1'b0, 8'd9},
        // R9 foreign function
        '{{6'b011111,5'd0,5'd7,5'd13,5'b00010,6'b100001}, A, 1'b1, 64'h0, 1'b0, 1'b0, 8'd9}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        valid_i = 1'b0;
    logic [31:0] instr_i = '0;
    logic [63:0] operand_i = '0;
    logic        wide_en_i = 1'b0;
    logic [63:0] res_o;
    logic [4:0]  dst_o;
    logic        res_valid_o;
    logic        illegal_o;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    reorder_unit uut (
        .clk(clk), .rst(rst), .valid_i(valid_i), .instr_i(instr_i),
        .operand_i(operand_i), .wide_en_i(wide_en_i), .res_o(res_o),
        .dst_o(dst_o), .res_valid_o(res_valid_o), .illegal_o(illegal_o)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req, input logic [63:0] er,
                             input logic [4:0] ed, input logic ev, input logic ei);
        chk(req, "res", res_o, er);
        chk(req, "dst", {59'd0, dst_o}, {59'd0, ed});
        chk(req, "valid", {63'd0, res_valid_o}, {63'd0, ev});
        chk(req, "illegal", {63'd0, illegal_o}, {63'd0, ei});
    endtask

    task automatic issue(input vec_t v);
        @(negedge clk);
        valid_i   = 1'b1;
        instr_i   = v.ins;
        operand_i = v.opnd;
        wide_en_i = v.wen;
    endtask

    initial begin
        for (int c = 0; c < 20000; c++) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        // R1: reset state, inputs busy during reset
        valid_i = 1'b1;
        instr_i = VECS[6].ins;
        operand_i = A;
        wide_en_i = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_all("R1", 64'h0, 5'd0, 1'b0, 1'b0);
        rst = 1'b0;
        valid_i = 1'b0;

        // table walk: each result one clock after issue (R10)
        for (int i = 0; i < NV; i++) begin
            issue(VECS[i]);
            @(negedge clk);
            valid_i = 1'b0;
            check_all($sformatf("R%0d", VECS[i].req), VECS[i].exp,
                      VECS[i].ev ? VECS[i].ins[15:11] : 5'd0, VECS[i].ev, VECS[i].ei);
        end

        // R10: idle cycle after an op yields zero outputs
        issue(VECS[0]);
        @(negedge clk);
        valid_i = 1'b0;
        @(negedge clk);
        check_all("R10", 64'h0, 5'd0, 1'b0, 1'b0);

        // R10: back-to-back stream, each output tied to the prior cycle
        issue(VECS[7]);
        issue(VECS[2]);
        check_all("R10", VECS[7].exp, VECS[7].ins[15:11], 1'b1, 1'b0);
        issue(VECS[8]);
        check_all("R10", VECS[2].exp, VECS[2].ins[15:11], 1'b1, 1'b0);
        @(negedge clk);
        valid_i = 1'b0;
        check_all("R7", 64'h0, 5'd0, 1'b0, 1'b1);

        // R1: reset mid-stream clears a pending result
        issue(VECS[6]);
        rst = 1'b1;
        @(negedge clk);
        valid_i = 1'b0;
        check_all("R1", 64'h0, 5'd0, 1'b0, 1'b0);
        rst = 1'b0;
        issue(VECS[6]);
        @(negedge clk);
        valid_i = 1'b0;
        check_all("R5", VECS[6].exp, VECS[6].ins[15:11], 1'b1, 1'b0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule